// File: doc/BRIEF.md
# Taken-Branch Redirect and Squash Control

This block handles control hazards in a five-stage in-order pipeline that keeps fetching sequential addresses past a conditional equality branch. Until the branch has been resolved, fetch keeps running at the sequential address, which amounts to predicting every branch as not taken. The branch works out its target and its equality result in execute. The result is acted on one stage later, when the branch sits in the EX/MEM pipeline register.

The block holds the fetch program counter. Each cycle it receives four inputs: the branch-valid flag, the equality result and the target from EX/MEM, and the sequential address that the datapath adder computes from the current fetch PC. A valid branch whose operands compared equal makes it load the target into the PC. On that same clock edge it asks the IF/ID, ID/EX and EX/MEM registers to load noops in place of the three younger instructions. A noop is an entry with its valid bit cleared, so it writes no register or memory and offers nothing to forwarding. A not-taken branch, or the absence of a branch, leaves fetch on the sequential path and squashes nothing.

Top module: `brsq_ctrl`

## Requirements
- R1: While `rst` is high, `pc_sel` and every bit of `squash` are 0. The edge that samples `rst` high loads `RESET_PC` into `fetch_pc`.
- R2: When `exm_br_vld` is 0, the block ignores `exm_br_eq` and `exm_br_tgt`. `pc_sel` is 0, `squash` is all zero, and the next edge loads `seq_pc` into `fetch_pc`.
- R3: A valid branch with `exm_br_eq` = 0 (not taken) acts like a noop. `pc_sel` is 0, nothing is squashed, and the next edge loads `seq_pc`.
- R4: A valid branch with `exm_br_eq` = 1 (taken) drives `pc_sel` to 1 in that cycle, and the next edge loads `exm_br_tgt` into `fetch_pc` instead of `seq_pc`.
- R5: In the same cycle as a taken branch, every bit of `squash` is 1. Bit 0 clears IF/ID, bit 1 clears ID/EX and bit 2 clears EX/MEM, so the squash and the redirect act on the same edge.
- R6: `squash` is never partial. It is either all zero or all ones, and it is all ones only when `pc_sel` is 1.
- R7: In a pipeline that follows `squash`, a taken branch is followed into MEM/WB by exactly three invalid (noop) slots and then by the instruction at the target. A not-taken branch is followed directly, with no bubble, by the instruction at its own address plus one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exm_br_vld | input | 1 | EX/MEM holds a valid conditional branch |
| exm_br_eq | input | 1 | Equality result of that branch, computed in execute |
| exm_br_tgt | input | ADDR_W | Branch target computed in execute |
| seq_pc | input | ADDR_W | Sequential address (fetch PC plus one) |
| fetch_pc | output | ADDR_W | Registered fetch program counter |
| pc_sel | output | 1 | 1 when the next PC is the branch target |
| squash | output | N_YOUNG | Noop request per younger stage: bit 0 IF/ID, bit 1 ID/EX, bit 2 EX/MEM |

## Verification
The bench builds the block with `ADDR_W` = 12, `N_YOUNG` = 3 and `RESET_PC` = 0x010. The narrow address lets short runs reach the sequential wrap from 0xFFF to 0x000 and all-ones or all-zero targets. With three younger stages, the squash vector matches the stage registers of a small pipeline model in the bench. That model counts the noop slots that reach MEM/WB after a taken branch and after a not-taken branch, and checks which instruction arrives next.

// File: rtl/brsq_pkg.sv
package brsq_pkg;

  // Source chosen for the next fetch address
  typedef enum logic {
    SEL_SEQ = 1'b0,
    SEL_TGT = 1'b1
  } pcsel_e;

endpackage

// File: rtl/brsq_resolve.sv
// Turns the EX/MEM branch fields into a redirect decision.
module brsq_resolve
  import brsq_pkg::*;
(
  input  logic   rst,
  input  logic   br_vld,
  input  logic   br_eq,
  output logic   redirect,
  output pcsel_e sel
);

  always_comb begin
    redirect = 1'b0;
    sel      = SEL_SEQ;
    if (!rst && br_vld && br_eq) begin
      redirect = 1'b1;
      sel      = SEL_TGT;
    end
  end

endmodule

// File: rtl/brsq_pc_mux.sv
// Picks the next fetch address from the sequential path or the branch target.
module brsq_pc_mux
  import brsq_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  pcsel_e              sel,
  input  logic [ADDR_W-1:0]   seq_addr,
  input  logic [ADDR_W-1:0]   tgt_addr,
  output logic [ADDR_W-1:0]   next_addr
);

  always_comb begin
    unique case (sel)
      SEL_TGT: next_addr = tgt_addr;
      default: next_addr = seq_addr;
    endcase
  end

endmodule

// File: rtl/brsq_squash_gen.sv
// One noop request per younger pipeline register, all raised by a redirect.
module brsq_squash_gen #(
  parameter int N_YOUNG = 3
) (
  input  logic               redirect,
  output logic [N_YOUNG-1:0] squash
);

  for (genvar s = 0; s < N_YOUNG; s++) begin : g_stage
    assign squash[s] = redirect;
  end

endmodule

// File: rtl/brsq_ctrl.sv
// Fetch PC register with a not-taken assumption and late taken-branch recovery.
module brsq_ctrl
  import brsq_pkg::*;
#(
  parameter int                ADDR_W   = 32,
  parameter int                N_YOUNG  = 3,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               exm_br_vld,
  input  logic               exm_br_eq,
  input  logic [ADDR_W-1:0]  exm_br_tgt,
  input  logic [ADDR_W-1:0]  seq_pc,
  output logic [ADDR_W-1:0]  fetch_pc,
  output logic               pc_sel,
  output logic [N_YOUNG-1:0] squash
);

  logic              redirect;
  pcsel_e            sel;
  logic [ADDR_W-1:0] next_pc;
  logic [ADDR_W-1:0] pc_q;

  brsq_resolve u_resolve (
    .rst      (rst),
    .br_vld   (exm_br_vld),
    .br_eq    (exm_br_eq),
    .redirect (redirect),
    .sel      (sel)
  );

  brsq_pc_mux #(.ADDR_W(ADDR_W)) u_mux (
    .sel       (sel),
    .seq_addr  (seq_pc),
    .tgt_addr  (exm_br_tgt),
    .next_addr (next_pc)
  );

  brsq_squash_gen #(.N_YOUNG(N_YOUNG)) u_squash (
    .redirect (redirect),
    .squash   (squash)
  );

  // The PC and the stage registers all take the redirect on one edge.
  always_ff @(posedge clk) begin
    if (rst) pc_q <= RESET_PC;
    else     pc_q <= next_pc;
  end

  assign fetch_pc = pc_q;
  assign pc_sel   = (sel == SEL_TGT);

endmodule

// File: rtl/brsq_ctrl_chk.sv
module brsq_ctrl_chk #(
  parameter int                ADDR_W   = 32,
  parameter int                N_YOUNG  = 3,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input logic               clk,
  input logic               rst,
  input logic               exm_br_vld,
  input logic               exm_br_eq,
  input logic [ADDR_W-1:0]  exm_br_tgt,
  input logic [ADDR_W-1:0]  seq_pc,
  input logic [ADDR_W-1:0]  fetch_pc,
  input logic               pc_sel,
  input logic [N_YOUNG-1:0] squash
);

  assert_reset_pc_R1: assert property (@(posedge clk)
    rst |=> fetch_pc == RESET_PC);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |-> (!pc_sel && squash == '0));

  assert_no_branch_seq_R2: assert property (@(posedge clk) disable iff (rst)
    !exm_br_vld |=> fetch_pc == $past(seq_pc));

  assert_not_taken_seq_R3: assert property (@(posedge clk) disable iff (rst)
    (exm_br_vld && !exm_br_eq) |=> fetch_pc == $past(seq_pc));

  assert_taken_target_R4: assert property (@(posedge clk) disable iff (rst)
    (exm_br_vld && exm_br_eq) |=> fetch_pc == $past(exm_br_tgt));

  assert_squash_with_redirect_R5: assert property (@(posedge clk) disable iff (rst)
    pc_sel |-> squash == {N_YOUNG{1'b1}});

  assert_squash_whole_R6: assert property (@(posedge clk) disable iff (rst)
    !pc_sel |-> squash == '0);

endmodule

bind brsq_ctrl brsq_ctrl_chk #(
  .ADDR_W   (ADDR_W),
  .N_YOUNG  (N_YOUNG),
  .RESET_PC (RESET_PC)
) u_chk (.*);

// File: tb/brsq_ctrl_test.sv
`timescale 1ns/1ps
module brsq_ctrl_test;

  localparam int          AW  = 12;
  localparam int          NY  = 3;
  localparam logic [AW-1:0] RPC = 12'h010;

  // {vld, eq, expected pc_sel, target}
  localparam logic [14:0] VEC [8] = '{
    {1'b0, 1'b0, 1'b0, 12'h123},
    {1'b0, 1'b1, 1'b0, 12'h3FF},
    {1'b1, 1'b0, 1'b0, 12'h200},
    {1'b1, 1'b1, 1'b1, 12'h040},
    {1'b1, 1'b1, 1'b1, 12'hFFF},
    {1'b1, 1'b1, 1'b1, 12'h000},
    {1'b1, 1'b0, 1'b0, 12'h555},
    {1'b0, 1'b0, 1'b0, 12'hAAA}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          vld = 1'b0;
  logic          eq  = 1'b0;
  logic [AW-1:0] tgt = '0;
  logic [AW-1:0] seq = '0;
  logic [AW-1:0] fetch_pc;
  logic          pc_sel;
  logic [NY-1:0] squash;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  brsq_ctrl #(.ADDR_W(AW), .N_YOUNG(NY), .RESET_PC(RPC)) uut (
    .clk(clk), .rst(rst), .exm_br_vld(vld), .exm_br_eq(eq), .exm_br_tgt(tgt),
    .seq_pc(seq), .fetch_pc(fetch_pc), .pc_sel(pc_sel), .squash(squash)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Pipeline model driven by squash: valid bit and pc per stage
  logic          ifid_v, idex_v, exm_v, mwb_v;
  logic [AW-1:0] ifid_p, idex_p, exm_p, mwb_p;

  task automatic run_pipe(input logic taken, input string req);
    logic [AW-1:0] br_pc;
    logic [AW-1:0] br_tgt;
    logic          seen;
    int            bubbles;
    logic          done;
    br_pc  = RPC + 12'd2;
    br_tgt = 12'h080;
    ifid_v = 0; idex_v = 0; exm_v = 0; mwb_v = 0;
    ifid_p = '0; idex_p = '0; exm_p = '0; mwb_p = '0;
    @(negedge clk); rst = 1'b1; vld = 0; eq = 0;
    @(negedge clk); rst = 1'b0;
    seen = 0; bubbles = 0; done = 0;
    for (int c = 0; c < 16 && !done; c++) begin
      vld = exm_v && (exm_p == br_pc);
      eq  = taken;
      tgt = br_tgt;
      seq = fetch_pc + 12'd1;
      #1;
      mwb_v = exm_v; mwb_p = exm_p;
      exm_v  = squash[2] ? 1'b0 : idex_v; exm_p  = idex_p;
      idex_v = squash[1] ? 1'b0 : ifid_v; idex_p = ifid_p;
      ifid_v = squash[0] ? 1'b0 : 1'b1;   ifid_p = fetch_pc;
      if (seen) begin
        if (!mwb_v) bubbles++;
        else begin
          check({req, " bubble count"}, bubbles, taken ? 3 : 0);
          check({req, " next instruction"}, mwb_p, taken ? br_tgt : br_pc + 12'd1);
          done = 1;
        end
      end else if (mwb_v && mwb_p == br_pc) seen = 1;
      @(negedge clk);
    end
    check({req, " sequence completed"}, done, 1);
    vld = 0; eq = 0;
  endtask

  initial begin : watchdog
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin : main
    logic [AW-1:0] exp_pc;
    // R1 reset state
    @(negedge clk); @(negedge clk);
    vld = 1; eq = 1; tgt = 12'h777; #1;
    check("R1 pc_sel in reset", pc_sel, 0);
    check("R1 squash in reset", squash, 0);
    @(negedge clk);
    check("R1 reset pc", fetch_pc, RPC);
    rst = 0; vld = 0; eq = 0;
    exp_pc = RPC;

    // Vector table: R2 R3 R4 R5 R6
    foreach (VEC[i]) begin
      vld = VEC[i][14]; eq = VEC[i][13]; tgt = VEC[i][11:0];
      seq = exp_pc + 12'd1;
      #1;
      check("R4 pc_sel", pc_sel, VEC[i][12]);
      check("R5 R6 squash", squash, VEC[i][12] ? 3'b111 : 3'b000);
      exp_pc = VEC[i][12] ? VEC[i][11:0] : exp_pc + 12'd1;
      @(negedge clk);
      check(VEC[i][12] ? "R4 target loaded" : (VEC[i][14] ? "R3 sequential" : "R2 sequential"),
            fetch_pc, exp_pc);
    end

    // Sequential wrap from all-ones (R2)
    vld = 1; eq = 1; tgt = 12'hFFF; seq = exp_pc + 12'd1;
    @(negedge clk);
    vld = 0; seq = 12'h000; #1;
    check("R2 squash idle", squash, 0);
    @(negedge clk);
    check("R2 wrap pc", fetch_pc, 12'h000);

    // Reset overrides a taken branch (R1)
    rst = 1; vld = 1; eq = 1; tgt = 12'h321; #1;
    check("R1 no squash under reset", squash, 0);
    @(negedge clk);
    check("R1 pc reset over branch", fetch_pc, RPC);
    rst = 0; vld = 0; eq = 0;

    // Pipeline bubble counting (R7)
    run_pipe(1'b1, "R7 taken");
    run_pipe(1'b0, "R7 not taken");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule